// File: doc/BRIEF.md
# Memory protection region checker

This block decides, for every 32-bit access address, whether the access is allowed. It compares the address with a parameterized set of protection regions. Each region is an arbitrary range with a lower and an upper bound, both on a 32-byte boundary. The result is a fault flag, a fault code, and the read, write and execute permissions that apply to the address.

A simple register write port programs each region's base word and limit word. The check itself is purely combinational, from the access inputs to the outputs.

No address translation is done: the physical address is always the input address. When two enabled regions both cover an address, the access faults. No region takes priority over another.

Several conditions bypass the region search and use a fixed background map instead:
- protection is turned off;
- the address falls in the private peripheral window;
- a privileged access is made while the privileged default map is enabled.

Top module: `mpc_top`

## Requirements
- R1: After reset every region is disabled. With protection on and the privileged default map off, any address outside the peripheral window faults with `fault_code` 0 and all permissions clear.
- R2: A region's range runs from its base word with bits [4:0] forced to 0 up to its limit word with bits [4:0] forced to 1. Both ends are included. Base bits [4:3] never affect the range.
- R3: Bit 0 of a region's limit word enables the region. A disabled region never matches.
- R4: When two or more enabled regions cover the address, the access faults with `fault_code` 0x0D and all permissions clear, whatever the regions' permissions are.
- R5: With `ctl_mpu_en` low, every access uses the background map. The background map grants read and write at any level, and grants execute outside 0xE0000000–0xFFFFFFFF.
- R6: Addresses 0xE0000000–0xE00FFFFF always use the background map, even when protection is on and no region is programmed.
- R7: When `ctl_priv_default` is high, a privileged access uses the background map and skips any region settings. A user access still goes through the region search.
- R8: For a single matching region, the 2-bit permission field sits in base word bits [2:1]:
  - 00: privileged read/write, no user access;
  - 01: read/write at any level;
  - 10: privileged read-only, no user access;
  - 11: read-only at any level.
- R9: Base word bit 0 is the region's execute-never flag. Execute is granted only when the region grants read or write at the current level and execute-never is clear.
- R10: Addresses 0xE0000000–0xFFFFFFFF never get execute permission, even in a region whose execute-never flag is clear.
- R11: `acc_type` is encoded 0 = read, 1 = write, 2 = instruction fetch.
  - If the permission for that type is not granted, the access faults with `fault_code` 0x0D, and the permission outputs still show what was granted.
  - Without a fault, `fault_code` is 0.
- R12: A write port sets a region word on a rising clock edge while `cfg_we` is high:
  - `cfg_idx` selects the region;
  - `cfg_sel` selects the word, 0 for the base word and 1 for the limit word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the region registers |
| rst | input | 1 | Synchronous active-high reset, clears all region words |
| cfg_we | input | 1 | Region word write strobe |
| cfg_idx | input | $clog2(NUM_REGIONS) | Region selected for writing |
| cfg_sel | input | 1 | 0 selects the base word, 1 the limit word |
| cfg_wdata | input | 32 | Data written to the selected word |
| ctl_mpu_en | input | 1 | Protection enable |
| ctl_priv_default | input | 1 | Background map enable for privileged accesses |
| acc_addr | input | 32 | Access address |
| acc_type | input | 2 | 0 read, 1 write, 2 fetch |
| acc_priv | input | 1 | 1 for a privileged access |
| fault | output | 1 | Access is refused |
| fault_code | output | 5 | 0x0D permission or overlap fault, 0 background fault or no fault |
| perm_rd | output | 1 | Read permitted |
| perm_wr | output | 1 | Write permitted |
| perm_ex | output | 1 | Execute permitted |

## Verification
Single regions are probed at their first and last byte and one byte past each end. This separates the forced-zero base bits from the forced-one limit bits, and a hit from a background miss. Each of the four permission codes is tried with privileged and user accesses of all three types, including a region whose execute-never bit is set. These patterns show which of the read, write and execute decisions is wrong.

An overlapping pair is tested inside its overlap and outside it, and then again after one of the pair is disabled. This tells an overlap fault apart from a priority choice. The peripheral window edges, protection off and the privileged default map are each tested against addresses that a region also covers or that lie in system space. This shows that the background bypass wins and that execute stays denied in system space.

// File: rtl/mpc_pkg.sv
package mpc_pkg;

    localparam int ADDR_W    = 32;
    localparam int FAULT_W   = 5;
    localparam int GRAN_BITS = 5;

    localparam logic [FAULT_W-1:0] FC_NONE  = 5'h00;
    localparam logic [FAULT_W-1:0] FC_BACKG = 5'h00;
    localparam logic [FAULT_W-1:0] FC_PERM  = 5'h0D;

    localparam logic [ADDR_W-1:0] PPB_LO = 32'hE000_0000;
    localparam logic [ADDR_W-1:0] PPB_HI = 32'hE00F_FFFF;
    localparam logic [ADDR_W-1:0] SYS_LO = 32'hE000_0000;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_kind_e;

    typedef struct packed {
        logic rd;
        logic wr;
        logic ex;
    } perm_t;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] limit;
    } region_t;

    typedef struct packed {
        logic [1:0] ap;
        logic       xn;
    } rgn_attr_t;

    function automatic logic in_ppb(input logic [ADDR_W-1:0] a);
        return (a >= PPB_LO) && (a <= PPB_HI);
    endfunction

    function automatic logic in_sys(input logic [ADDR_W-1:0] a);
        return a >= SYS_LO;
    endfunction

    // Read/write grant for a 2-bit permission code at the given level.
    function automatic perm_t ap_grant(input logic [1:0] ap, input logic priv);
        perm_t p;
        p.ex = 1'b0;
        p.rd = priv | ap[0];
        p.wr = (priv | ap[0]) & ~ap[1];
        return p;
    endfunction

endpackage

// File: rtl/mpc_region_bank.sv
module mpc_region_bank
    import mpc_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    localparam int IDX_W = $clog2(NUM_REGIONS)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         we,
    input  logic [IDX_W-1:0]             idx,
    input  logic                         sel,
    input  logic [ADDR_W-1:0]            wdata,
    output region_t [NUM_REGIONS-1:0]    regions
);

    region_t [NUM_REGIONS-1:0] regs_q;

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_rgn
        always_ff @(posedge clk) begin
            if (rst) begin
                regs_q[g] <= '0;
            end else if (we && (idx == IDX_W'(g))) begin
                if (sel) regs_q[g].limit <= wdata;
                else     regs_q[g].base  <= wdata;
            end
        end
    end

    assign regions = regs_q;

endmodule

// File: rtl/mpc_region_match.sv
module mpc_region_match
    import mpc_pkg::*;
#(
    parameter int NUM_REGIONS = 8
) (
    input  region_t [NUM_REGIONS-1:0] regions,
    input  logic [ADDR_W-1:0]         addr,
    output logic [NUM_REGIONS-1:0]    hit_vec,
    output rgn_attr_t                 sel_attr
);

    rgn_attr_t [NUM_REGIONS-1:0] attr_masked;

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_cmp
        logic [ADDR_W-1:0] lo, hi;
        assign lo = {regions[g].base[ADDR_W-1:GRAN_BITS],  {GRAN_BITS{1'b0}}};
        assign hi = {regions[g].limit[ADDR_W-1:GRAN_BITS], {GRAN_BITS{1'b1}}};
        assign hit_vec[g] = regions[g].limit[0] && (addr >= lo) && (addr <= hi);
        assign attr_masked[g] = hit_vec[g] ? rgn_attr_t'(regions[g].base[2:0]) : '0;
    end

    // OR-combine; only meaningful when exactly one region hits.
    always_comb begin
        sel_attr = '0;
        for (int i = 0; i < NUM_REGIONS; i++) begin
            sel_attr = sel_attr | attr_masked[i];
        end
    end

endmodule

// File: rtl/mpc_perm_eval.sv
module mpc_perm_eval
    import mpc_pkg::*;
#(
    parameter int NUM_REGIONS = 8
) (
    input  logic                      mpu_en,
    input  logic                      priv_default,
    input  logic                      priv,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [1:0]                kind,
    input  logic [NUM_REGIONS-1:0]    hit_vec,
    input  rgn_attr_t                 attr,
    output logic                      fault,
    output logic [FAULT_W-1:0]        code,
    output perm_t                     perm
);

    logic use_bg, any_hit, multi_hit, sys, granted;
    perm_t rw;

    assign sys       = in_sys(addr);
    assign use_bg    = !mpu_en || in_ppb(addr) || (priv_default && priv);
    assign any_hit   = |hit_vec;
    assign multi_hit = |(hit_vec & (hit_vec - NUM_REGIONS'(1)));
    assign rw        = ap_grant(attr.ap, priv);

    always_comb begin
        perm  = '0;
        fault = 1'b0;
        code  = FC_NONE;
        if (use_bg) begin
            perm.rd = 1'b1;
            perm.wr = 1'b1;
            perm.ex = !sys;
        end else if (multi_hit) begin
            fault = 1'b1;
            code  = FC_PERM;
        end else if (!any_hit) begin
            fault = 1'b1;
            code  = FC_BACKG;
        end else begin
            perm.rd = rw.rd;
            perm.wr = rw.wr;
            perm.ex = (rw.rd | rw.wr) && !attr.xn && !sys;
        end

        if (use_bg || (any_hit && !multi_hit)) begin
            unique case (kind)
                ACC_READ:  granted = perm.rd;
                ACC_WRITE: granted = perm.wr;
                ACC_FETCH: granted = perm.ex;
                default:   granted = 1'b0;
            endcase
            if (!granted) begin
                fault = 1'b1;
                code  = FC_PERM;
            end
        end else begin
            granted = 1'b0;
        end
    end

endmodule

// File: rtl/mpc_top.sv
module mpc_top
    import mpc_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    localparam int IDX_W = $clog2(NUM_REGIONS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic [IDX_W-1:0]   cfg_idx,
    input  logic               cfg_sel,
    input  logic [31:0]        cfg_wdata,
    input  logic               ctl_mpu_en,
    input  logic               ctl_priv_default,
    input  logic [31:0]        acc_addr,
    input  logic [1:0]         acc_type,
    input  logic               acc_priv,
    output logic               fault,
    output logic [4:0]         fault_code,
    output logic               perm_rd,
    output logic               perm_wr,
    output logic               perm_ex
);

    region_t [NUM_REGIONS-1:0] regions;
    logic [NUM_REGIONS-1:0]    hit_vec;
    rgn_attr_t                 sel_attr;
    perm_t                     perm;

    mpc_region_bank #(.NUM_REGIONS(NUM_REGIONS)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .we      (cfg_we),
        .idx     (cfg_idx),
        .sel     (cfg_sel),
        .wdata   (cfg_wdata),
        .regions (regions)
    );

    mpc_region_match #(.NUM_REGIONS(NUM_REGIONS)) u_match (
        .regions  (regions),
        .addr     (acc_addr),
        .hit_vec  (hit_vec),
        .sel_attr (sel_attr)
    );

    mpc_perm_eval #(.NUM_REGIONS(NUM_REGIONS)) u_eval (
        .mpu_en       (ctl_mpu_en),
        .priv_default (ctl_priv_default),
        .priv         (acc_priv),
        .addr         (acc_addr),
        .kind         (acc_type),
        .hit_vec      (hit_vec),
        .attr         (sel_attr),
        .fault        (fault),
        .code         (fault_code),
        .perm         (perm)
    );

    assign perm_rd = perm.rd;
    assign perm_wr = perm.wr;
    assign perm_ex = perm.ex;

endmodule

// File: rtl/mpc_checker.sv
module mpc_checker (
    input logic        clk,
    input logic        rst,
    input logic        ctl_mpu_en,
    input logic [31:0] acc_addr,
    input logic [1:0]  acc_type,
    input logic        fault,
    input logic [4:0]  fault_code,
    input logic        perm_rd,
    input logic        perm_wr,
    input logic        perm_ex
);

    // R5: protection off never refuses a data access
    a_r5_off_data_ok: assert property (@(posedge clk) disable iff (rst)
        (!ctl_mpu_en && acc_type != 2'd2) |-> !fault);

    // R9: execute only alongside some read/write grant
    a_r9_ex_needs_rw: assert property (@(posedge clk) disable iff (rst)
        perm_ex |-> (perm_rd || perm_wr));

    // R10: system space never executable
    a_r10_sys_no_exec: assert property (@(posedge clk) disable iff (rst)
        (acc_addr[31:29] == 3'b111) |-> !perm_ex);

    // R11: no fault means code zero
    a_r11_code_clear: assert property (@(posedge clk) disable iff (rst)
        !fault |-> (fault_code == 5'h00));

    // R11: a granted read never faults
    a_r11_read_granted: assert property (@(posedge clk) disable iff (rst)
        (acc_type == 2'd0 && perm_rd) |-> !fault);

    // R1: background fault carries no permissions
    a_r1_bg_fault_noperm: assert property (@(posedge clk) disable iff (rst)
        (fault && fault_code == 5'h00) |-> !(perm_rd || perm_wr || perm_ex));

endmodule

bind mpc_top mpc_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .ctl_mpu_en (ctl_mpu_en),
    .acc_addr   (acc_addr),
    .acc_type   (acc_type),
    .fault      (fault),
    .fault_code (fault_code),
    .perm_rd    (perm_rd),
    .perm_wr    (perm_wr),
    .perm_ex    (perm_ex)
);

// File: tb/tb_mpc_top.sv
module tb_mpc_top;

    localparam int CLK_PERIOD = 10;
    localparam int NREG = 8;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [2:0]  cfg_idx;
    logic        cfg_sel;
    logic [31:0] cfg_wdata;
    logic        ctl_mpu_en;
    logic        ctl_priv_default;
    logic [31:0] acc_addr;
    logic [1:0]  acc_type;
    logic        acc_priv;
    logic        fault;
    logic [4:0]  fault_code;
    logic        perm_rd, perm_wr, perm_ex;

    int n_checks = 0;
    int n_fails  = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mpc_top #(.NUM_REGIONS(NREG)) dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .ctl_mpu_en(ctl_mpu_en),
        .ctl_priv_default(ctl_priv_default), .acc_addr(acc_addr),
        .acc_type(acc_type), .acc_priv(acc_priv), .fault(fault),
        .fault_code(fault_code), .perm_rd(perm_rd), .perm_wr(perm_wr),
        .perm_ex(perm_ex)
    );

    localparam logic [1:0] RD = 2'd0, WR = 2'd1, FE = 2'd2;

    task automatic wr_reg(input int idx, input bit sel, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Apply an access, then compare {fault, code, rwx}.
    task automatic probe(input string req, input logic [31:0] a, input logic [1:0] t,
                         input bit pr, input bit ef, input logic [4:0] ec,
                         input logic [2:0] ep);
        logic [2:0] got;
        acc_addr = a; acc_type = t; acc_priv = pr;
        #1;
        got = {perm_rd, perm_wr, perm_ex};
        n_checks++;
        if (fault !== ef || fault_code !== ec || got !== ep) begin
            n_fails++;
            $display("FAIL %s addr=%h type=%0d priv=%0b: actual fault=%0b code=%h rwx=%b expected fault=%0b code=%h rwx=%b",
                     req, a, t, pr, fault, fault_code, got, ef, ec, ep);
        end
    endtask

    task automatic t_reset;
        ctl_mpu_en = 1'b1; ctl_priv_default = 1'b0;
        probe("R1", 32'h0000_1000, RD, 1'b0, 1'b1, 5'h00, 3'b000);
        probe("R1", 32'h2000_0000, WR, 1'b1, 1'b1, 5'h00, 3'b000);
    endtask

    task automatic t_range;
        // R12: region 0 base (ap=01, xn=0) then limit (enabled)
        wr_reg(0, 1'b0, 32'h2000_001A);
        wr_reg(0, 1'b1, 32'h2000_0FE1);
        probe("R2", 32'h2000_0000, RD, 1'b0, 1'b0, 5'h00, 3'b111);
        probe("R2", 32'h2000_0FFF, WR, 1'b0, 1'b0, 5'h00, 3'b111);
        probe("R2", 32'h2000_1000, RD, 1'b0, 1'b1, 5'h00, 3'b000);
        probe("R2", 32'h1FFF_FFFF, RD, 1'b0, 1'b1, 5'h00, 3'b000);
        probe("R12", 32'h2000_0800, FE, 1'b0, 1'b0, 5'h00, 3'b111);
    endtask

    task automatic t_enable;
        wr_reg(0, 1'b1, 32'h2000_0FE0);
        probe("R3", 32'h2000_0FFF, RD, 1'b1, 1'b1, 5'h00, 3'b000);
        wr_reg(0, 1'b1, 32'h2000_0FE1);
        probe("R3", 32'h2000_0FFF, RD, 1'b1, 1'b0, 5'h00, 3'b111);
    endtask

    task automatic t_ap;
        wr_reg(1, 1'b0, 32'h3000_0004);  // ap=10
        wr_reg(1, 1'b1, 32'h3000_00E1);
        probe("R8", 32'h3000_0010, RD, 1'b1, 1'b0, 5'h00, 3'b101);
        probe("R8", 32'h3000_0010, WR, 1'b1, 1'b1, 5'h0D, 3'b101);
        probe("R8", 32'h3000_0010, RD, 1'b0, 1'b1, 5'h0D, 3'b000);
        wr_reg(2, 1'b0, 32'h4000_0007);  // ap=11, xn=1
        wr_reg(2, 1'b1, 32'h4000_00E1);
        probe("R8", 32'h4000_0020, RD, 1'b0, 1'b0, 5'h00, 3'b100);
        probe("R9", 32'h4000_0020, FE, 1'b1, 1'b1, 5'h0D, 3'b100);
        probe("R11", 32'h4000_0020, WR, 1'b0, 1'b1, 5'h0D, 3'b100);
        wr_reg(3, 1'b0, 32'h5000_0000);  // ap=00
        wr_reg(3, 1'b1, 32'h5000_00E1);
        probe("R8", 32'h5000_0040, WR, 1'b1, 1'b0, 5'h00, 3'b111);
        probe("R8", 32'h5000_0040, RD, 1'b0, 1'b1, 5'h0D, 3'b000);
        probe("R9", 32'h5000_0040, FE, 1'b0, 1'b1, 5'h0D, 3'b000);
    endtask

    task automatic t_overlap;
        wr_reg(4, 1'b0, 32'h2000_0802);
        wr_reg(4, 1'b1, 32'h2000_1FE1);
        probe("R4", 32'h2000_0900, RD, 1'b1, 1'b1, 5'h0D, 3'b000);
        probe("R4", 32'h2000_1800, RD, 1'b0, 1'b0, 5'h00, 3'b111);
        wr_reg(4, 1'b1, 32'h2000_1FE0);
        probe("R4", 32'h2000_0900, RD, 1'b1, 1'b0, 5'h00, 3'b111);
    endtask

    task automatic t_sys;
        wr_reg(5, 1'b0, 32'hF000_0002);  // ap=01, xn=0
        wr_reg(5, 1'b1, 32'hF000_00E1);
        probe("R10", 32'hF000_0010, FE, 1'b0, 1'b1, 5'h0D, 3'b110);
        probe("R10", 32'hF000_0010, RD, 1'b0, 1'b0, 5'h00, 3'b110);
    endtask

    task automatic t_ppb;
        probe("R6", 32'hE000_0100, RD, 1'b0, 1'b0, 5'h00, 3'b110);
        probe("R6", 32'hE00F_FFFF, WR, 1'b0, 1'b0, 5'h00, 3'b110);
        probe("R6", 32'hE010_0000, RD, 1'b0, 1'b1, 5'h00, 3'b000);
    endtask

    task automatic t_mpu_off;
        ctl_mpu_en = 1'b0;
        probe("R5", 32'h0000_1000, FE, 1'b0, 1'b0, 5'h00, 3'b111);
        probe("R5", 32'h3000_0010, WR, 1'b0, 1'b0, 5'h00, 3'b111);
        probe("R5", 32'hF000_0010, FE, 1'b0, 1'b1, 5'h0D, 3'b110);
        ctl_mpu_en = 1'b1;
    endtask

    task automatic t_priv_default;
        ctl_priv_default = 1'b1;
        probe("R7", 32'h0000_1000, RD, 1'b1, 1'b0, 5'h00, 3'b111);
        probe("R7", 32'h0000_1000, RD, 1'b0, 1'b1, 5'h00, 3'b000);
        probe("R7", 32'h3000_0010, WR, 1'b1, 1'b0, 5'h00, 3'b111);
        probe("R7", 32'h3000_0010, RD, 1'b0, 1'b1, 5'h0D, 3'b000);
        ctl_priv_default = 1'b0;
    endtask

    initial begin
        rst = 1'b1; cfg_we = 1'b0; cfg_idx = '0; cfg_sel = 1'b0; cfg_wdata = '0;
        ctl_mpu_en = 1'b0; ctl_priv_default = 1'b0;
        acc_addr = '0; acc_type = RD; acc_priv = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_range();
        t_enable();
        t_ap();
        t_overlap();
        t_sys();
        t_ppb();
        t_mpu_off();
        t_priv_default();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_fails++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule